// File: doc/BRIEF.md
# Label Equivalence Resolution Engine

This block runs between the two scans of a connected-component labeling flow. Once the first scan has handed out provisional labels and logged every pair of provisional labels found to touch, the block reads that pair list and fills a translation table. The table has one entry per provisional label and holds the final label for it. All provisional labels joined by a chain of pairs get one shared final label. Final labels are numbered densely from zero.

A host pulses `start` with the number of provisional labels and the number of stored pairs. The engine then sweeps the provisional labels in ascending order. The first label of each new group takes the next final number and goes onto a work queue. For every label taken off the queue, the engine reads the whole pair list, one entry at a time. Any partner that has no final label yet gets the current number and is queued. When the queue drains, that group is closed.

Control comes from a small microcode decoder. Its next state and its control word are picked by the current state together with status flags: end of pair list, queue empty, partner match, end of sweep and label already taken. Run time grows with the product of label count and pair count.

Top module: `label_resolver`

## Requirements
- R1: After reset, `busy`, `done`, `tbl_we` and `pair_rd` are all low.
- R2: `start` is accepted only while `busy` is low. `lbl_count` and `pair_count` are captured in that cycle. Later changes to `start`, `lbl_count` or `pair_count` while busy do not change the result and do not cause a second `done`.
- R3: In each run, every provisional label from 0 to `lbl_count`-1 is written to the table exactly once. No other address is written.
- R4: Two provisional labels get the same final label exactly when a chain of stored pairs joins them. This holds whatever the order of the pairs and whichever side of a pair a label sits on.
- R5: Final labels are 0 to G-1, where G is the number of groups. Groups are numbered in ascending order of their smallest provisional label, so the group holding label 0 gets final label 0.
- R6: A provisional label that appears in no stored pair, or only in pairs with itself, gets a final label of its own.
- R7: `done` is high for exactly one cycle per run. In that cycle `final_count` equals G. `busy` is low from the next cycle.
- R8: `pair_rd` addresses only entries below the captured pair count and is never high two cycles in a row. `pair_a` and `pair_b` are taken in the cycle after `pair_rd`.
- R9: `tbl_we` is high only while `busy` is high.
- R10: With `lbl_count` zero, the run writes nothing, reads no pairs and finishes with `final_count` zero.
- R11: Each run issues exactly `lbl_count` × `pair_count` pair reads, because every label is dequeued once and each dequeue reads the full pair list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken while idle |
| lbl_count | input | LBL_W+1 | Number of provisional labels |
| pair_count | input | PAIR_AW+1 | Number of stored merge pairs |
| pair_rd | output | 1 | Pair memory read strobe |
| pair_addr | output | PAIR_AW | Pair memory read address |
| pair_a | input | LBL_W | First label of the pair read, one cycle after `pair_rd` |
| pair_b | input | LBL_W | Second label of the pair read, one cycle after `pair_rd` |
| tbl_we | output | 1 | Translation table write enable |
| tbl_addr | output | LBL_W | Provisional label being written |
| tbl_data | output | LBL_W | Final label written |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| final_count | output | LBL_W+1 | Number of final labels, valid with `done` |

## Verification
The bench targets these corner cases:
- A chain of pairs stored in descending order. Label 0 reaches label 15 only through repeated full passes, so an engine that scans the list once, or stops early, splits the chain.
- Self-pairs and pairs duplicated in both orientations. A design that keys only on the first side of a pair, or does not check whether the partner is already taken, leaves labels behind or writes them twice.
- Entries past the pair count filled with labels that would merge groups if read. Reading past the count corrupts the table, and the exact read count exposes an early exit.
- Zero labels, zero pairs, a full 32-entry list, and a restart attempt while busy. A design that re-latches its counts mid-run then returns the wrong mapping or a second `done`.

// File: rtl/lr_pkg.sv
package lr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INIT,
      ST_SCAN,
      ST_POP,
      ST_REQ,
      ST_CHK,
      ST_DONE
   } lr_state_e;

   // status flags that, with the state, form the microcode address
   typedef struct packed {
      logic go;
      logic scan_end;
      logic scan_taken;
      logic q_empty;
      logic tbl_end;
      logic hit_free;
   } lr_status_t;

   // control word produced by the microcode decoder
   typedef struct packed {
      lr_state_e nxt;
      logic      latch;
      logic      init;
      logic      scan_inc;
      logic      take_scan;
      logic      pop;
      logic      rd;
      logic      pair_inc;
      logic      take_partner;
      logic      fin_inc;
      logic      done;
   } lr_uop_t;

endpackage

// File: rtl/lr_ucode.sv
module lr_ucode
   import lr_pkg::*;
(
   input  lr_state_e  state,
   input  lr_status_t stat,
   output lr_uop_t    uop
);

   // address = {state, status}; each state inspects only the flags it needs
   always_comb begin
      uop     = '0;
      uop.nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (stat.go) begin
               uop.latch = 1'b1;
               uop.nxt   = ST_INIT;
            end
         end
         ST_INIT: begin
            uop.init = 1'b1;
            uop.nxt  = ST_SCAN;
         end
         ST_SCAN: begin
            if (stat.scan_end) begin
               uop.nxt = ST_DONE;
            end else if (stat.scan_taken) begin
               uop.scan_inc = 1'b1;
            end else begin
               uop.take_scan = 1'b1;
               uop.nxt       = ST_POP;
            end
         end
         ST_POP: begin
            if (stat.q_empty) begin
               uop.fin_inc  = 1'b1;
               uop.scan_inc = 1'b1;
               uop.nxt      = ST_SCAN;
            end else begin
               uop.pop = 1'b1;
               uop.nxt = ST_REQ;
            end
         end
         ST_REQ: begin
            if (stat.tbl_end) begin
               uop.nxt = ST_POP;
            end else begin
               uop.rd  = 1'b1;
               uop.nxt = ST_CHK;
            end
         end
         ST_CHK: begin
            uop.pair_inc     = 1'b1;
            uop.take_partner = stat.hit_free;
            uop.nxt          = ST_REQ;
         end
         ST_DONE: begin
            uop.done = 1'b1;
            uop.nxt  = ST_IDLE;
         end
         default: uop.nxt = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/lr_flags.sv
module lr_flags #(
   parameter int LBL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set_en,
   input  logic [LBL_W-1:0] set_idx,
   input  logic [LBL_W-1:0] rd_a_idx,
   output logic             rd_a,
   input  logic [LBL_W-1:0] rd_b_idx,
   output logic             rd_b
);

   localparam int NL = 1 << LBL_W;

   logic [NL-1:0] bits_q;
   logic [NL-1:0] set_vec;

   for (genvar i = 0; i < NL; i++) begin : g_dec
      assign set_vec[i] = set_en && (set_idx == LBL_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bits_q <= '0;
      else if (clr) bits_q <= '0;
      else          bits_q <= bits_q | set_vec;
   end

   assign rd_a = bits_q[rd_a_idx];
   assign rd_b = bits_q[rd_b_idx];

endmodule

// File: rtl/lr_queue.sv
module lr_queue #(
   parameter int LBL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [LBL_W-1:0] push_data,
   input  logic             pop,
   output logic [LBL_W-1:0] head,
   output logic             empty
);

   localparam int NL = 1 << LBL_W;

   logic [LBL_W-1:0] mem [NL];
   logic [LBL_W:0]   wp_q, rp_q;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q[LBL_W-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else if (clr) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   assign head  = mem[rp_q[LBL_W-1:0]];
   assign empty = (wp_q == rp_q);

endmodule

// File: rtl/label_resolver.sv
module label_resolver
   import lr_pkg::*;
#(
   parameter int LBL_W   = 6,
   parameter int PAIR_AW = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LBL_W:0]     lbl_count,
   input  logic [PAIR_AW:0]   pair_count,
   output logic               pair_rd,
   output logic [PAIR_AW-1:0] pair_addr,
   input  logic [LBL_W-1:0]   pair_a,
   input  logic [LBL_W-1:0]   pair_b,
   output logic               tbl_we,
   output logic [LBL_W-1:0]   tbl_addr,
   output logic [LBL_W-1:0]   tbl_data,
   output logic               busy,
   output logic               done,
   output logic [LBL_W:0]     final_count
);

   if (LBL_W < 1 || LBL_W > 10) begin : g_bad_lbl_w
      $error("label_resolver: LBL_W must lie in 1..10");
   end
   if (PAIR_AW < 1 || PAIR_AW > 12) begin : g_bad_pair_aw
      $error("label_resolver: PAIR_AW must lie in 1..12");
   end

   lr_state_e        state_q;
   lr_status_t       stat;
   lr_uop_t          uop;

   logic [LBL_W:0]   scan_q, fin_q, cnt_q;
   logic [PAIR_AW:0] pidx_q, pcnt_q;
   logic [LBL_W-1:0] cur_q;

   logic [LBL_W-1:0] scan_idx, partner, q_head, set_idx;
   logic             scan_taken, partner_taken, q_empty;
   logic             a_hit, b_hit, take;

   assign scan_idx = scan_q[LBL_W-1:0];
   assign a_hit    = (pair_a == cur_q);
   assign b_hit    = (pair_b == cur_q);
   assign partner  = a_hit ? pair_b : pair_a;

   always_comb begin
      stat            = '0;
      stat.go         = start;
      stat.scan_end   = (scan_q == cnt_q);
      stat.scan_taken = scan_taken;
      stat.q_empty    = q_empty;
      stat.tbl_end    = (pidx_q == pcnt_q);
      stat.hit_free   = (a_hit | b_hit) & ~partner_taken;
   end

   lr_ucode u_ucode (
      .state (state_q),
      .stat  (stat),
      .uop   (uop)
   );

   assign take    = uop.take_scan | uop.take_partner;
   assign set_idx = uop.take_scan ? scan_idx : partner;

   lr_flags #(.LBL_W(LBL_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (uop.init),
      .set_en   (take),
      .set_idx  (set_idx),
      .rd_a_idx (scan_idx),
      .rd_a     (scan_taken),
      .rd_b_idx (partner),
      .rd_b     (partner_taken)
   );

   lr_queue #(.LBL_W(LBL_W)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (uop.init),
      .push      (take),
      .push_data (set_idx),
      .pop       (uop.pop),
      .head      (q_head),
      .empty     (q_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         scan_q  <= '0;
         fin_q   <= '0;
         cnt_q   <= '0;
         pcnt_q  <= '0;
         pidx_q  <= '0;
         cur_q   <= '0;
      end else begin
         state_q <= uop.nxt;
         if (uop.latch) begin
            cnt_q  <= lbl_count;
            pcnt_q <= pair_count;
         end
         if (uop.init) begin
            scan_q <= '0;
            fin_q  <= '0;
         end else begin
            if (uop.scan_inc) scan_q <= scan_q + 1'b1;
            if (uop.fin_inc)  fin_q  <= fin_q + 1'b1;
         end
         if (uop.pop) begin
            cur_q  <= q_head;
            pidx_q <= '0;
         end else if (uop.pair_inc) begin
            pidx_q <= pidx_q + 1'b1;
         end
      end
   end

   assign pair_rd     = uop.rd;
   assign pair_addr   = pidx_q[PAIR_AW-1:0];
   assign tbl_we      = take;
   assign tbl_addr    = set_idx;
   assign tbl_data    = fin_q[LBL_W-1:0];
   assign busy        = (state_q != ST_IDLE);
   assign done        = uop.done;
   assign final_count = fin_q;

endmodule

// File: rtl/lr_chk.sv
module lr_chk #(
   parameter int LBL_W   = 6,
   parameter int PAIR_AW = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [LBL_W:0]     lbl_count,
   input logic [PAIR_AW:0]   pair_count,
   input logic               pair_rd,
   input logic [PAIR_AW-1:0] pair_addr,
   input logic               tbl_we,
   input logic [LBL_W-1:0]   tbl_addr,
   input logic [LBL_W-1:0]   tbl_data,
   input logic               busy,
   input logic               done,
   input logic [LBL_W:0]     final_count
);

   localparam int NL = 1 << LBL_W;

   logic [LBL_W:0]   run_cnt, wcount;
   logic [PAIR_AW:0] run_pc;
   logic [NL-1:0]    wmask;
   logic             seen_any;
   logic [LBL_W-1:0] seen_max;
   logic [LBL_W:0]   groups_seen;
   logic             accept;

   assign accept      = start && !busy;
   assign groups_seen = seen_any ? ({1'b0, seen_max} + 1'b1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         run_pc   <= '0;
         wcount   <= '0;
         wmask    <= '0;
         seen_any <= 1'b0;
         seen_max <= '0;
      end else if (accept) begin
         run_cnt  <= lbl_count;
         run_pc   <= pair_count;
         wcount   <= '0;
         wmask    <= '0;
         seen_any <= 1'b0;
         seen_max <= '0;
      end else if (tbl_we) begin
         wcount          <= wcount + 1'b1;
         wmask[tbl_addr] <= 1'b1;
         seen_any        <= 1'b1;
         if (!seen_any || tbl_data > seen_max) seen_max <= tbl_data;
      end
   end

   // R2
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R3
   no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> !wmask[tbl_addr]);

   // R3
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> ({1'b0, tbl_addr} < run_cnt));

   // R3
   all_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wcount == run_cnt));

   // R5
   dense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> ({1'b0, tbl_data} <= groups_seen));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R7
   group_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (final_count == groups_seen));

   // R8
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_rd |-> (busy && ({1'b0, pair_addr} < run_pc)));

   // R8
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_rd |=> !pair_rd);

   // R9
   we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> busy);

endmodule

bind label_resolver lr_chk #(.LBL_W(LBL_W), .PAIR_AW(PAIR_AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .lbl_count   (lbl_count),
   .pair_count  (pair_count),
   .pair_rd     (pair_rd),
   .pair_addr   (pair_addr),
   .tbl_we      (tbl_we),
   .tbl_addr    (tbl_addr),
   .tbl_data    (tbl_data),
   .busy        (busy),
   .done        (done),
   .final_count (final_count)
);

// File: tb/sim_label_resolver.sv
module sim_label_resolver;

   localparam int CLK_NS = 10;
   localparam int LW     = 4;
   localparam int PW     = 5;
   localparam int NL     = 1 << LW;
   localparam int NP     = 1 << PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW:0]   lbl_count = '0;
   logic [PW:0]   pair_count = '0;
   logic          pair_rd;
   logic [PW-1:0] pair_addr;
   logic [LW-1:0] pair_a, pair_b;
   logic          tbl_we;
   logic [LW-1:0] tbl_addr, tbl_data;
   logic          busy, done;
   logic [LW:0]   final_count;

   always #(CLK_NS/2) clk = ~clk;

   label_resolver #(.LBL_W(LW), .PAIR_AW(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .lbl_count(lbl_count), .pair_count(pair_count),
      .pair_rd(pair_rd), .pair_addr(pair_addr),
      .pair_a(pair_a), .pair_b(pair_b),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .busy(busy), .done(done), .final_count(final_count)
   );

   // pair memory with one cycle of read latency
   logic [LW-1:0] ma [NP];
   logic [LW-1:0] mb [NP];
   always @(posedge clk) begin
      if (pair_rd) begin
         pair_a <= ma[pair_addr];
         pair_b <= mb[pair_addr];
      end
   end

   // observation of the table port, reads and done
   int          run_id = 0;
   int          tb_run [NL];
   logic [LW-1:0] tb_val [NL];
   int          wr_tot = 0, dup_tot = 0, rd_tot = 0, done_tot = 0;
   logic [LW:0] fc_cap = '0;

   always @(posedge clk) begin
      if (tbl_we) begin
         if (tb_run[tbl_addr] == run_id) dup_tot <= dup_tot + 1;
         tb_run[tbl_addr] <= run_id;
         tb_val[tbl_addr] <= tbl_data;
         wr_tot <= wr_tot + 1;
      end
      if (pair_rd) rd_tot <= rd_tot + 1;
      if (done) begin
         done_tot <= done_tot + 1;
         fc_cap   <= final_count;
      end
   end

   int      checks = 0;
   int      errors = 0;
   int unsigned seed = 32'h1234_5678;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed >> 16);
   endfunction

   task automatic fill_junk();
      for (int k = 0; k < NP; k++) begin
         ma[k] = LW'(rnd());
         mb[k] = LW'(rnd());
      end
   endtask

   task automatic run(input int n, input int np, input bit poke, input string tag);
      int comp [NL];
      int fid  [NL];
      int groups;
      bit chg;
      int wr0, dup0, rd0, dn0, waited;
      // expected grouping: relax each label to the smallest label it reaches
      for (int i = 0; i < NL; i++) comp[i] = i;
      chg = 1'b1;
      while (chg) begin
         chg = 1'b0;
         for (int k = 0; k < np; k++) begin
            int a, b, m;
            a = int'(ma[k]);
            b = int'(mb[k]);
            m = (comp[a] < comp[b]) ? comp[a] : comp[b];
            if (comp[a] != m) begin comp[a] = m; chg = 1'b1; end
            if (comp[b] != m) begin comp[b] = m; chg = 1'b1; end
         end
      end
      groups = 0;
      for (int i = 0; i < n; i++) begin
         if (comp[i] == i) begin
            fid[i] = groups;
            groups++;
         end
      end
      @(negedge clk);
      run_id++;
      wr0 = wr_tot; dup0 = dup_tot; rd0 = rd_tot; dn0 = done_tot;
      lbl_count  = (LW+1)'(n);
      pair_count = (PW+1)'(np);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         start      = 1'b1;
         lbl_count  = '0;
         pair_count = '0;
         repeat (3) @(negedge clk);
         start      = 1'b0;
      end
      waited = 0;
      while (done_tot == dn0 && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      repeat (4) @(negedge clk);
      chk("R7", {tag, " done pulses"}, done_tot - dn0, 1);
      chk("R7", {tag, " busy after done"}, int'(busy), 0);
      chk("R7", {tag, " final_count"}, int'(fc_cap), groups);
      chk("R3 R9", {tag, " write total"}, wr_tot - wr0, n);
      chk("R3", {tag, " duplicate writes"}, dup_tot - dup0, 0);
      chk("R8 R11", {tag, " pair reads"}, rd_tot - rd0, n * np);
      for (int i = 0; i < n; i++) begin
         chk("R3", {tag, $sformatf(" label %0d written", i)}, int'(tb_run[i] == run_id), 1);
         chk("R4 R5 R6", {tag, $sformatf(" final of label %0d", i)},
             int'(tb_val[i]), fid[comp[i]]);
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      fill_junk();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "tbl_we after reset", int'(tbl_we), 0);
      chk("R1", "pair_rd after reset", int'(pair_rd), 0);

      // R10: no labels at all
      run(0, 5, 1'b0, "R10 empty");

      // R6: no pairs, every label alone
      fill_junk();
      run(NL, 0, 1'b0, "R6 no pairs");

      // R4: descending chain that needs repeated passes
      fill_junk();
      for (int k = 0; k < NL - 1; k++) begin
         ma[k] = LW'(NL - 1 - k);
         mb[k] = LW'(NL - 2 - k);
      end
      run(NL, NL - 1, 1'b0, "R4 chain");

      // R6: self pairs and a pair stored in both orientations
      fill_junk();
      ma[0] = 4'd2; mb[0] = 4'd2;
      ma[1] = 4'd4; mb[1] = 4'd1;
      ma[2] = 4'd1; mb[2] = 4'd4;
      ma[3] = 4'd3; mb[3] = 4'd3;
      run(6, 4, 1'b0, "R6 self pairs");

      // R2: full table, restart attempt and count change mid-run
      fill_junk();
      run(NL, NP, 1'b1, "R2 poke");

      // R8: sweep of random configurations, junk past pair_count
      for (int t = 0; t < 30; t++) begin
         int n, np;
         fill_junk();
         n  = 1 + (rnd() % NL);
         np = rnd() % (NP + 1);
         for (int k = 0; k < np; k++) begin
            ma[k] = LW'(rnd() % n);
            mb[k] = LW'(rnd() % n);
         end
         run(n, np, 1'b0, $sformatf("R5 sweep %0d", t));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule